// File: doc/BRIEF.md
# Thirty-Two-Bit Integer ALU with Sparse Operation Codes

This block is a purely combinational arithmetic and logic unit for a small 32-bit processor datapath. Two operands, `op_x` and `op_y`, and a 4-bit operation select drive a 32-bit result. The unit also drives two flags. The first reports two's-complement overflow, but only for the trapping add and subtract operations. The second reports operand equality, whatever operation is selected.

The unit does shifts, addition and subtraction in trapping and non-trapping forms, bitwise AND and OR, and signed and unsigned less-than comparisons. For every shift, the value shifted is `op_y` and the distance comes from the low bits of `op_x`. The operation codes are fixed and not contiguous. Codes with no operation assigned give a zero result.

Top module: `alu_core`

## Requirements
- R1: Select 0 shifts `op_y` left by `op_x[4:0]`, filling with zeros. Select 1 shifts `op_y` right by `op_x[4:0]`, filling with zeros. Select 2 shifts `op_y` right by `op_x[4:0]`, filling with copies of bit 31. Bits 31:5 of `op_x` have no effect on any shift.
- R2: Selects 5 and 6 both give `op_x + op_y`, modulo 2^32.
- R3: Selects 7 and 8 both give `op_x - op_y`, modulo 2^32.
- R4: `ovf` is high only for select 5 or select 7, and only when the signed sum (select 5) or the signed difference (select 7) lies outside [-2^31, 2^31-1]. For every other select it is low.
- R5: Select 9 gives the bitwise AND of the operands and select 10 gives their bitwise OR.
- R6: Select 11 gives 1 when `op_x < op_y` as signed two's-complement values, and 0 otherwise. Select 12 does the same comparison on unsigned values. Bits 31:1 of the result are zero for both.
- R7: `equal` is high exactly when `op_x == op_y`, for all sixteen select values.
- R8: Selects 3, 4, 13, 14 and 15 give a zero result with `ovf` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 32 | First operand; supplies the shift distance for shifts |
| op_y | input | 32 | Second operand; the value shifted for shifts |
| op_sel | input | 4 | Operation select code |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of trapping add or subtract |
| equal | output | 1 | Operands are equal |

## Verification
Signed overflow is the hardest case to reach. Random operands hit it often for add, but rarely at the exact boundary, and the flag must also stay low when the same overflowing operands are applied with the non-trapping codes. The stimulus therefore applies each boundary pair, such as 0x7FFFFFFF plus 1 and 0x80000000 minus 1, under every one of the sixteen codes. It also applies operand pairs that differ only in the upper bits of `op_x`, to show that those bits do not change a shift. Random operand sweeps cover every code on top of these directed cases.

// File: rtl/alu_core.sv
module alu_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             ovf,
  output logic             equal
);
  localparam int SHW = $clog2(WIDTH);
  localparam logic [3:0] SEL_SLL  = 4'd0;
  localparam logic [3:0] SEL_SRL  = 4'd1;
  localparam logic [3:0] SEL_SRA  = 4'd2;
  localparam logic [3:0] SEL_ADD  = 4'd5;
  localparam logic [3:0] SEL_ADDU = 4'd6;
  localparam logic [3:0] SEL_SUB  = 4'd7;
  localparam logic [3:0] SEL_SUBU = 4'd8;
  localparam logic [3:0] SEL_AND  = 4'd9;
  localparam logic [3:0] SEL_OR   = 4'd10;
  localparam logic [3:0] SEL_SLT  = 4'd11;
  localparam logic [3:0] SEL_SLTU = 4'd12;

  logic [SHW-1:0]          amt;
  logic [WIDTH-1:0]        sum, diff;
  logic signed [WIDTH-1:0] y_sgn, x_sgn;
  logic                    add_ov, sub_ov, lt_s, lt_u;

  assign amt    = op_x[SHW-1:0];
  assign x_sgn  = op_x;
  assign y_sgn  = op_y;
  assign sum    = op_x + op_y;
  assign diff   = op_x - op_y;
  assign add_ov = (op_x[WIDTH-1] == op_y[WIDTH-1]) && (sum[WIDTH-1]  != op_x[WIDTH-1]);
  assign sub_ov = (op_x[WIDTH-1] != op_y[WIDTH-1]) && (diff[WIDTH-1] != op_x[WIDTH-1]);
  assign lt_s   = x_sgn < y_sgn;
  assign lt_u   = op_x < op_y;
  assign equal  = op_x == op_y;

  always_comb begin
    result = '0;
    unique case (op_sel)
      SEL_SLL:            result = op_y << amt;
      SEL_SRL:            result = op_y >> amt;
      SEL_SRA:            result = y_sgn >>> amt;
      SEL_ADD, SEL_ADDU:  result = sum;
      SEL_SUB, SEL_SUBU:  result = diff;
      SEL_AND:            result = op_x & op_y;
      SEL_OR:             result = op_x | op_y;
      SEL_SLT:            result = {{(WIDTH-1){1'b0}}, lt_s};
      SEL_SLTU:           result = {{(WIDTH-1){1'b0}}, lt_u};
      default:            result = '0;
    endcase
  end

  assign ovf = ((op_sel == SEL_ADD) && add_ov) || ((op_sel == SEL_SUB) && sub_ov);
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_x,
  input logic [WIDTH-1:0] op_y,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             ovf,
  input logic             equal
);
  always_comb begin
    p_ovf_codes_r4: assert (!ovf || op_sel == 4'd5 || op_sel == 4'd7)
      else $error("ovf raised for select %0d", op_sel);
    if (op_sel == 4'd5 && ovf)
      p_add_ov_sign_r4: assert (op_x[WIDTH-1] == op_y[WIDTH-1] && result[WIDTH-1] != op_x[WIDTH-1])
        else $error("add ovf without sign change");
    if (op_sel == 4'd7 && ovf)
      p_sub_ov_sign_r4: assert (op_x[WIDTH-1] != op_y[WIDTH-1] && result[WIDTH-1] != op_x[WIDTH-1])
        else $error("sub ovf without sign change");
    if (op_sel == 4'd3 || op_sel == 4'd4 || op_sel >= 4'd13)
      p_unused_zero_r8: assert (result == '0 && !ovf)
        else $error("unassigned select gave nonzero output");
    if (op_sel == 4'd11 || op_sel == 4'd12)
      p_slt_onebit_r6: assert (result[WIDTH-1:1] == '0)
        else $error("compare result wider than one bit");
    if (op_sel == 4'd8)
      p_eq_diff_zero_r7: assert (equal == (result == '0))
        else $error("equal disagrees with zero difference");
    if (op_sel == 4'd9 && equal)
      p_and_equal_r5: assert (result == op_y)
        else $error("AND of equal operands differs");
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_x(op_x), .op_y(op_y), .op_sel(op_sel),
  .result(result), .ovf(ovf), .equal(equal)
);

// File: tb/alu_core_bench.sv
`timescale 1ns/1ps
module alu_core_bench;
  typedef struct {
    logic [31:0] x, y;
    logic [3:0]  sel;
    logic [31:0] res;
    logic        ov, eq;
  } item_t;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] op_x = '0, op_y = '0, result;
  logic [3:0]  op_sel = '0;
  logic        ovf, equal;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;
  item_t       q[$];

  always #2.5 clk = ~clk;

  alu_core u_alu_core (.op_x(op_x), .op_y(op_y), .op_sel(op_sel),
                       .result(result), .ovf(ovf), .equal(equal));

  function automatic string req_of(logic [3:0] s);
    case (s)
      4'd0, 4'd1, 4'd2:  return "R1";
      4'd5, 4'd6:        return "R2";
      4'd7, 4'd8:        return "R3";
      4'd9, 4'd10:       return "R5";
      4'd11, 4'd12:      return "R6";
      default:           return "R8";
    endcase
  endfunction

  function automatic item_t model(logic [31:0] x, logic [31:0] y, logic [3:0] s);
    item_t  it;
    longint wide;
    logic [31:0] r;
    int     n;
    it.x = x; it.y = y; it.sel = s; it.ov = 0; it.res = 0;
    it.eq = (x ^ y) == 0;
    n = int'(x % 32);
    r = y;
    case (s)
      4'd0: begin for (int i = 0; i < n; i++) r = {r[30:0], 1'b0}; it.res = r; end
      4'd1: begin for (int i = 0; i < n; i++) r = {1'b0, r[31:1]}; it.res = r; end
      4'd2: begin for (int i = 0; i < n; i++) r = {r[31], r[31:1]}; it.res = r; end
      4'd5, 4'd6: begin
        wide = longint'($signed(x)) + longint'($signed(y));
        it.res = wide[31:0];
        it.ov = (s == 4'd5) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      4'd7, 4'd8: begin
        wide = longint'($signed(x)) - longint'($signed(y));
        it.res = wide[31:0];
        it.ov = (s == 4'd7) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      4'd9:  it.res = ~(~x | ~y);
      4'd10: it.res = ~(~x & ~y);
      4'd11: it.res = (longint'($signed(x)) < longint'($signed(y))) ? 32'd1 : 32'd0;
      4'd12: it.res = (longint'({32'd0, x}) < longint'({32'd0, y})) ? 32'd1 : 32'd0;
      default: it.res = 0;
    endcase
    return it;
  endfunction

  task automatic drive(logic [31:0] x, logic [31:0] y, logic [3:0] s);
    @(posedge clk);
    #1;
    op_x = x; op_y = y; op_sel = s;
    q.push_back(model(x, y, s));
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t e;
      bit bad;
      e = q.pop_front();
      n_run++;
      bad = 0;
      if (result !== e.res) begin
        bad = 1;
        $display("FAIL %s sel=%0d x=%h y=%h result actual=%h expected=%h",
                 req_of(e.sel), e.sel, e.x, e.y, result, e.res);
      end
      if (ovf !== e.ov) begin
        bad = 1;
        $display("FAIL R4 sel=%0d x=%h y=%h ovf actual=%b expected=%b",
                 e.sel, e.x, e.y, ovf, e.ov);
      end
      if (equal !== e.eq) begin
        bad = 1;
        $display("FAIL R7 sel=%0d x=%h y=%h equal actual=%b expected=%b",
                 e.sel, e.x, e.y, equal, e.eq);
      end
      if (bad) n_fail++;
    end
  end

  initial begin
    logic [31:0] corner_x [8];
    logic [31:0] corner_y [8];
    void'($urandom(7));
    repeat (3) @(posedge clk);
    rst = 0;
    drive(32'h0, 32'h0, 4'd0);  // R7 idle state: zero inputs, equal high
    corner_x = '{32'h7FFFFFFF, 32'h80000000, 32'h80000000, 32'h7FFFFFFF,
                 32'd31, 32'hFFFFFFE3, 32'h12345678, 32'hFFFFFFFF};
    corner_y = '{32'd1, 32'd1, 32'h80000000, 32'hFFFFFFFF,
                 32'h80000001, 32'h80000001, 32'h12345678, 32'd1};
    // R4 boundary pairs and R1 upper shift bits under every code
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 16; s++)
        drive(corner_x[c], corner_y[c], 4'(s));
    // R1 bits 31:5 of op_x ignored: same low bits, different upper bits
    for (int s = 0; s < 3; s++) begin
      drive(32'h00000004, 32'hC0FFEE01, 4'(s));
      drive(32'hABCDE004, 32'hC0FFEE01, 4'(s));
    end
    // R7 equal operands under all codes, R6 sign-differing compares
    for (int s = 0; s < 16; s++) begin
      logic [31:0] v;
      v = $urandom;
      drive(v, v, 4'(s));
      drive(32'hFFFFFFFF, 32'd0, 4'(s));
    end
    // random sweep, all codes
    for (int k = 0; k < 60; k++)
      for (int s = 0; s < 16; s++)
        drive($urandom, $urandom, 4'(s));
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule